// File: doc/BRIEF.md
# Serial 12-bit I/O expander

This block turns a four-wire serial port into twelve open-drain general-purpose pins. A host lowers the active-low select line to open a frame. At that moment the block takes a snapshot of every pin. While the host toggles the shift clock, the block sends the snapshot out one bit per falling edge and takes in a new pin pattern one bit per rising edge. When the host raises select again, the new pattern goes to the output latch that drives the pins.

Each pin is open-drain. A latched 0 pulls the pin low. A latched 1 releases the pin, and the pin then works as an input. The value read back from a pin is the external level ANDed with its own latched bit. The select, shift clock and serial input are sampled by a faster system clock through synchronizers, and every action happens on edges detected from the synchronized signals.

Top module: `sio_expander`

## Requirements
- R1: On a falling edge of cs_ni, the capture register loads pin_i & latch. Bit k holds pin k+1.
- R2: Right after the frame opens, sdo_o presents capture bit 0 (pin 1). Each accepted falling edge of sck_i advances sdo_o by one bit, so pins 1 to N_PINS appear in order.
- R3: On each of the first N_PINS rising edges of sck_i in a frame, sdi_i is sampled. The first bit sampled is destined for pin 1 (latch bit 0) and the last for pin N_PINS.
- R4: Rising edges of sck_i after the N_PINS-th in a frame are ignored, and the extra sdi_i bits never reach the latch. sdo_oe_o drops after the N_PINS-th falling edge.
- R5: The latch changes only on a rising edge of cs_ni, when it takes the contents of the update register. Between those edges it holds its value.
- R6: pin_oe_o[k] is 1 (pin k+1 pulled low) exactly when latch bit k is 0.
- R7: If cs_ni rises before the N_PINS-th clock, the latch takes the partially shifted update register at once. Both shift registers keep running, and sdo_oe_o stays high, until the N_PINS-th clock.
- R8: While rst_ni is low, sdo_oe_o is 0 and all pins are released (pin_oe_o all 0). The latch and the update register reset to all ones.
- R9: sdo_oe_o rises when a frame opens and stays high until the frame's N_PINS-th falling edge of sck_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples the serial inputs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Frame select, active low |
| sck_i | input | 1 | Shift clock, idles low |
| sdi_i | input | 1 | Serial write data |
| sdo_o | output | 1 | Serial read data |
| sdo_oe_o | output | 1 | Output enable for sdo_o; 0 means high impedance |
| pin_i | input | N_PINS | External level on each pin |
| pin_oe_o | output | N_PINS | Pull-low enable for each pin |

## Verification
The bench builds the block with N_PINS = 4. At that size it can sweep all sixteen write patterns against all sixteen external pin levels, with each frame's readback depending on the latch left by the frame before. The small width also makes it cheap to try an early deselect after every possible clock count, and to overclock frames so that the ignored-edge rule is exercised. Expected latch, capture and update values come from a shift-register model inside the bench.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  function automatic edge_t detect(input logic prev, input logic cur);
    edge_t e;
    e.rise = ~prev & cur;
    e.fall = prev & ~cur;
    return e;
  endfunction
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sio_frame_ctrl.sv
module sio_frame_ctrl
  import sio_pkg::*;
#(
  parameter int N_PINS = 12,
  localparam int CW = $clog2(N_PINS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_s_i,
  input  logic sck_s_i,
  output logic open_o,
  output logic close_o,
  output logic rise_take_o,
  output logic fall_take_o,
  output logic shift_en_o
);
  localparam logic [CW-1:0] LAST = CW'(N_PINS);

  logic          cs_q, sck_q, shift_en_q;
  logic [CW-1:0] bit_cnt_q;
  edge_t         cs_e, sck_e;

  assign cs_e  = detect(cs_q, cs_s_i);
  assign sck_e = detect(sck_q, sck_s_i);

  assign open_o      = cs_e.fall;
  assign close_o     = cs_e.rise;
  assign rise_take_o = sck_e.rise & shift_en_q & (bit_cnt_q < LAST) & ~cs_e.fall;
  assign fall_take_o = sck_e.fall & shift_en_q & (bit_cnt_q != '0) & ~cs_e.fall;
  assign shift_en_o  = shift_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q       <= 1'b1;
      sck_q      <= 1'b0;
      shift_en_q <= 1'b0;
      bit_cnt_q  <= '0;
    end else begin
      cs_q  <= cs_s_i;
      sck_q <= sck_s_i;
      if (cs_e.fall) begin
        shift_en_q <= 1'b1;
        bit_cnt_q  <= '0;
      end else begin
        if (rise_take_o) bit_cnt_q <= bit_cnt_q + 1'b1;
        // frame ends on the falling edge that follows the last accepted rise
        if (fall_take_o && bit_cnt_q == LAST) shift_en_q <= 1'b0;
      end
    end
  end

  p_cnt_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_e.rise && !cs_e.fall && bit_cnt_q == LAST) |=> (bit_cnt_q == LAST));

  p_frame_open_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_e.fall |=> (shift_en_q && bit_cnt_q == '0));
endmodule

// File: rtl/sio_shift.sv
module sio_shift #(
  parameter int N_PINS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [N_PINS-1:0] load_val_i,
  input  logic              rise_take_i,
  input  logic              fall_take_i,
  input  logic              sdi_i,
  input  logic              commit_i,
  output logic              sdo_o,
  output logic [N_PINS-1:0] latch_o
);
  logic [N_PINS-1:0] cap_q, upd_q, latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q   <= '0;
      upd_q   <= '1;
      latch_q <= '1;
    end else begin
      if (load_i)           cap_q <= load_val_i;
      else if (fall_take_i) cap_q <= {1'b0, cap_q[N_PINS-1:1]};
      // first bit received ends in bit 0 after N_PINS shifts
      if (rise_take_i) upd_q <= {sdi_i, upd_q[N_PINS-1:1]};
      if (commit_i)    latch_q <= upd_q;
    end
  end

  assign sdo_o   = cap_q[0];
  assign latch_o = latch_q;

  p_cap_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cap_q == $past(load_val_i)));

  p_latch_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(latch_q));

  p_upd_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_take_i |=> $stable(upd_q));
endmodule

// File: rtl/sio_expander.sv
module sio_expander #(
  parameter int N_PINS      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_oe_o
);
  logic [2:0]        raw, syn;
  logic              open_w, close_w, rise_w, fall_w, shift_en_w;
  logic [N_PINS-1:0] latch_w;

  assign raw = {cs_ni, sck_i, sdi_i};

  sio_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  sio_frame_ctrl #(.N_PINS(N_PINS)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_s_i(syn[2]), .sck_s_i(syn[1]),
    .open_o(open_w), .close_o(close_w), .rise_take_o(rise_w),
    .fall_take_o(fall_w), .shift_en_o(shift_en_w)
  );

  sio_shift #(.N_PINS(N_PINS)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(open_w),
    .load_val_i(pin_i & latch_w), .rise_take_i(rise_w), .fall_take_i(fall_w),
    .sdi_i(syn[0]), .commit_i(close_w), .sdo_o(sdo_o), .latch_o(latch_w)
  );

  assign sdo_oe_o = shift_en_w;
  assign pin_oe_o = ~latch_w;

  p_oe_only_on_close_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !close_w |=> $stable(pin_oe_o));
endmodule

// File: tb/sio_expander_test.sv
module sio_expander_test;
  localparam int N = 4;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [N-1:0] pin = '0;
  logic sdo, sdo_oe;
  logic [N-1:0] pin_oe;

  int checks = 0, errors = 0;
  logic [N-1:0] m_lat = '1, m_upd = '1, m_cap = '0;

  always #2.5 clk = ~clk;

  sio_expander #(.N_PINS(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .pin_i(pin), .pin_oe_o(pin_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // nclk shift clocks; early>0 raises select after that many rises
  task automatic frame(input logic [31:0] wd, input logic [N-1:0] ext, input int nclk, input int early);
    pin  = ext;
    cs_n = 1'b0;
    tick(W);
    m_cap = ext & m_lat;
    chk(sdo_oe === 1'b1, "R9 oe at open", 32'(sdo_oe), 1);
    chk(sdo === m_cap[0], "R1/R2 first bit", 32'(sdo), 32'(m_cap[0]));
    for (int i = 0; i < nclk; i++) begin
      sdi = wd[i];
      tick(4);
      sck = 1'b1;
      tick(W);
      if (i < N) m_upd = {wd[i], m_upd[N-1:1]};
      if (early == i + 1) begin
        cs_n = 1'b1;
        tick(W);
        m_lat = m_upd;
        chk(pin_oe === ~m_lat, "R7 early latch", 32'(pin_oe), 32'(~m_lat));
      end
      sck = 1'b0;
      tick(W);
      if (i < N - 1) begin
        chk(sdo_oe === 1'b1, "R7/R9 oe mid", 32'(sdo_oe), 1);
        chk(sdo === m_cap[i+1], "R2 serial bit", 32'(sdo), 32'(m_cap[i+1]));
      end else begin
        chk(sdo_oe === 1'b0, "R4 hiz after last", 32'(sdo_oe), 0);
      end
    end
    chk(pin_oe === ~m_lat, "R5 latch held in frame", 32'(pin_oe), 32'(~m_lat));
    if (early == 0) begin
      cs_n = 1'b1;
      tick(W);
      m_lat = m_upd;
      chk(pin_oe === ~m_lat, "R3/R5/R6 commit", 32'(pin_oe), 32'(~m_lat));
    end
    tick(W);
  endtask

  initial begin
    tick(3);
    chk(sdo_oe === 1'b0, "R8 reset sdo hiz", 32'(sdo_oe), 0);
    chk(pin_oe === '0, "R8 reset pins released", 32'(pin_oe), 0);
    rst_n = 1'b1;
    tick(4);
    chk(pin_oe === '0, "R8 after reset", 32'(pin_oe), 0);
    // R1 R2 R3 R5 R6: full sweep of write data vs external level
    for (int w = 0; w < (1 << N); w++)
      for (int e = 0; e < (1 << N); e++)
        frame(32'(w), N'(e), N, 0);
    // R4: extra clocks with inverted data must not reach the latch
    for (int w = 0; w < (1 << N); w++) begin
      frame({24'h0, ~N'(w), N'(w)}, N'(w ^ 5), N + 4, 0);
      chk(pin_oe === ~N'(w), "R4 extra bits ignored", 32'(pin_oe), 32'(~N'(w)));
    end
    // R7: early deselect after every clock count
    for (int k = 1; k < N; k++)
      for (int w = 0; w < (1 << N); w += 3)
        frame(32'(w), N'(15 - w), N, k);
    // R7: early deselect with a truncated frame
    frame(32'h5, '1, 2, 1);
    frame(32'ha, '1, N, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule